// File: doc/BRIEF.md
# Register bank save allocator

This block makes the save decision on interrupt entry. It works out where the processor context goes: into the next free hardware register bank, onto the memory stack, or nowhere, with a bank overflow exception raised in its place. It holds a pointer over 15 banks, indexed 0 to 14. The pointer counts how many banks are occupied. When a handler returns, the block undoes the most recent bank save. The circuits that copy the registers and the stack memory traffic are outside this block. It produces only the control strobes and the bank index for them.

A bank holds R0 to R14, the global base register, the high and low multiply-accumulate registers, the procedure register and the vector number of the interrupt. The register copy belongs to the external datapath, which uses `save_index`. The vector number is kept inside the block in a small memory with one entry per bank. On restore, that memory returns the vector saved in the bank being released.

All outputs are registered. Each outcome appears as a one-cycle pulse on the clock edge after the request. The pointer changes on the same edge.

Top module: `bank_save_alloc`

## Requirements
- R1: A synchronous reset sets `bank_ptr` to 0 and clears every strobe and `banks_full`.
- R2: An entry of kind 3'd0 (maskable interrupt) with `bank_enable` = 1 and `bank_ptr` below 15 does three things one cycle later: it pulses `save_bank`, sets `save_index` to the old pointer and `save_vector` to the entry vector, and raises `bank_ptr` by one.
- R3: Entries of kinds 3'd1 (non-maskable), 3'd2 (user break), 3'd3 (address error), 3'd4 (bus error), 3'd5 (instruction exception) and the unused codes 6 and 7 produce no bank save, no stack save and no overflow, and leave `bank_ptr` unchanged.
- R4: With `bank_enable` = 0, a maskable entry produces no strobe and leaves `bank_ptr` unchanged.
- R5: A maskable banked entry with `bank_ptr` = 15 and `ovf_exc_enable` = 0 pulses `save_stack` and leaves `bank_ptr` at 15.
- R6: A maskable banked entry with `bank_ptr` = 15 and `ovf_exc_enable` = 1 pulses `ovf_exc` and leaves `bank_ptr` at 15.
- R7: `banks_full` is 1 exactly when `bank_ptr` equals 15, and `bank_ptr` never exceeds 15.
- R8: A return (`ret_valid`) with `bank_ptr` above 0 does three things one cycle later: it pulses `restore_bank`, sets `restore_index` to the old pointer minus one, and lowers `bank_ptr` by one. `restore_vector` then carries the vector saved into that bank, so vectors come back last-in, first-out.
- R9: A return with `bank_ptr` = 0 pulses `underflow` and leaves `bank_ptr` at 0 (no wrap).
- R10: When `entry_valid` and `ret_valid` are both 1 in the same cycle, the entry is handled and the return is ignored.
- R11: At most one of `save_bank`, `save_stack`, `ovf_exc`, `restore_bank`, `underflow` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_valid | input | 1 | Exception entry request, one cycle |
| entry_kind | input | 3 | Exception kind code (0 = maskable interrupt) |
| entry_vector | input | VEC_W (8) | Vector number of the entry |
| bank_enable | input | 1 | Register bank use enabled |
| ovf_exc_enable | input | 1 | 1: overflow exception when full; 0: stack fallback |
| ret_valid | input | 1 | Return-from-handler restore request, one cycle |
| save_bank | output | 1 | Bank save strobe |
| save_index | output | PTR_W (4) | Bank to write |
| save_vector | output | VEC_W (8) | Vector number stored with the bank |
| save_stack | output | 1 | Stack fallback save request |
| ovf_exc | output | 1 | Bank overflow exception request |
| restore_bank | output | 1 | Bank restore strobe |
| restore_index | output | PTR_W (4) | Bank to read back |
| restore_vector | output | VEC_W (8) | Vector saved in the restored bank |
| underflow | output | 1 | Return requested with no bank in use |
| bank_ptr | output | PTR_W (4) | Number of banks in use |
| banks_full | output | 1 | All banks in use |

## Verification
The bench fills all 15 banks and then requests another banked entry under both overflow settings. A design with an off-by-one limit would either write a sixteenth bank index or fall back to the stack one entry too early. It unwinds the full stack of banks and compares every returned vector against a last-in, first-out queue. A wrong read address or a read taken after the pointer moves shows up as a shifted vector. It then issues returns at pointer 0, where a wrapping pointer would jump to 15 instead of flagging underflow. It also sends every non-banked kind code, entries with banking disabled, and entries that coincide with returns. These catch a design that banks the wrong kinds or that honours both requests at once.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic [2:0] {
    KIND_IRQ   = 3'd0,
    KIND_NMI   = 3'd1,
    KIND_UBRK  = 3'd2,
    KIND_ADDR  = 3'd3,
    KIND_BUS   = 3'd4,
    KIND_INSN  = 3'd5
  } exc_kind_e;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_BANK  = 3'd1,
    ACT_STACK = 3'd2,
    ACT_OVF   = 3'd3,
    ACT_POP   = 3'd4,
    ACT_UNDER = 3'd5
  } bsa_act_e;

  // Only maskable interrupts may place context in a register bank.
  function automatic logic kind_is_bankable(input logic [2:0] kind);
    return kind == KIND_IRQ;
  endfunction

endpackage

// File: rtl/bsa_decide.sv
module bsa_decide
  import bsa_pkg::*;
(
  input  logic       entry_valid,
  input  logic [2:0] entry_kind,
  input  logic       bank_enable,
  input  logic       ovf_exc_enable,
  input  logic       ret_valid,
  input  logic       full,
  input  logic       empty,
  output bsa_act_e   action
);

  logic banked;

  always_comb begin
    banked = entry_valid && bank_enable && kind_is_bankable(entry_kind);
    action = ACT_NONE;
    if (entry_valid) begin
      if (banked) begin
        if (!full)               action = ACT_BANK;
        else if (ovf_exc_enable) action = ACT_OVF;
        else                     action = ACT_STACK;
      end
    end else if (ret_valid) begin
      action = empty ? ACT_UNDER : ACT_POP;
    end
  end

endmodule

// File: rtl/bsa_ptr.sv
module bsa_ptr #(
  parameter int NUM_BANKS = 15,
  parameter int PTR_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [PTR_W-1:0] ptr,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_BANKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (inc && (ptr != LIMIT)) begin
      ptr <= ptr + 1'b1;
    end else if (dec && (ptr != '0)) begin
      ptr <= ptr - 1'b1;
    end
  end

  assign full  = (ptr == LIMIT);
  assign empty = (ptr == '0);

endmodule

// File: rtl/bsa_vec_ram.sv
module bsa_vec_ram #(
  parameter int DEPTH = 15,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bank_save_alloc.sv
module bank_save_alloc
  import bsa_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int VEC_W     = 8,
  localparam int PTR_W    = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_valid,
  input  logic [2:0]       entry_kind,
  input  logic [VEC_W-1:0] entry_vector,
  input  logic             bank_enable,
  input  logic             ovf_exc_enable,
  input  logic             ret_valid,
  output logic             save_bank,
  output logic [PTR_W-1:0] save_index,
  output logic [VEC_W-1:0] save_vector,
  output logic             save_stack,
  output logic             ovf_exc,
  output logic             restore_bank,
  output logic [PTR_W-1:0] restore_index,
  output logic [VEC_W-1:0] restore_vector,
  output logic             underflow,
  output logic [PTR_W-1:0] bank_ptr,
  output logic             banks_full
);

  bsa_act_e         act;
  logic             ptr_empty;
  logic [PTR_W-1:0] pop_addr;
  logic             do_bank;
  logic             do_pop;

  bsa_decide u_decide (
    .entry_valid    (entry_valid),
    .entry_kind     (entry_kind),
    .bank_enable    (bank_enable),
    .ovf_exc_enable (ovf_exc_enable),
    .ret_valid      (ret_valid),
    .full           (banks_full),
    .empty          (ptr_empty),
    .action         (act)
  );

  assign do_bank  = (act == ACT_BANK);
  assign do_pop   = (act == ACT_POP);
  assign pop_addr = bank_ptr - 1'b1;

  bsa_ptr #(
    .NUM_BANKS (NUM_BANKS),
    .PTR_W     (PTR_W)
  ) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .inc   (do_bank),
    .dec   (do_pop),
    .ptr   (bank_ptr),
    .full  (banks_full),
    .empty (ptr_empty)
  );

  bsa_vec_ram #(
    .DEPTH (NUM_BANKS),
    .AW    (PTR_W),
    .DW    (VEC_W)
  ) u_vec_ram (
    .clk   (clk),
    .we    (do_bank),
    .waddr (bank_ptr),
    .wdata (entry_vector),
    .re    (do_pop),
    .raddr (pop_addr),
    .rdata (restore_vector)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      save_bank     <= 1'b0;
      save_stack    <= 1'b0;
      ovf_exc       <= 1'b0;
      restore_bank  <= 1'b0;
      underflow     <= 1'b0;
      save_index    <= '0;
      save_vector   <= '0;
      restore_index <= '0;
    end else begin
      save_bank    <= do_bank;
      save_stack   <= (act == ACT_STACK);
      ovf_exc      <= (act == ACT_OVF);
      restore_bank <= do_pop;
      underflow    <= (act == ACT_UNDER);
      if (do_bank) begin
        save_index  <= bank_ptr;
        save_vector <= entry_vector;
      end
      if (do_pop) restore_index <= pop_addr;
    end
  end

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int NUM_BANKS = 15,
  parameter int VEC_W     = 8,
  localparam int PTR_W    = $clog2(NUM_BANKS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             entry_valid,
  input logic [2:0]       entry_kind,
  input logic [VEC_W-1:0] entry_vector,
  input logic             bank_enable,
  input logic             ovf_exc_enable,
  input logic             ret_valid,
  input logic             save_bank,
  input logic [PTR_W-1:0] save_index,
  input logic [VEC_W-1:0] save_vector,
  input logic             save_stack,
  input logic             ovf_exc,
  input logic             restore_bank,
  input logic [PTR_W-1:0] restore_index,
  input logic [VEC_W-1:0] restore_vector,
  input logic             underflow,
  input logic [PTR_W-1:0] bank_ptr,
  input logic             banks_full
);

  logic banked_req;
  assign banked_req = entry_valid && (entry_kind == 3'd0) && bank_enable;

  AST_BANK_SAVE: assert property (@(posedge clk) disable iff (rst)
    banked_req && !banks_full |=> save_bank && save_index == $past(bank_ptr)
      && save_vector == $past(entry_vector) && bank_ptr == $past(bank_ptr) + 1'b1); // R2

  AST_NO_BANK_KIND: assert property (@(posedge clk) disable iff (rst)
    entry_valid && entry_kind != 3'd0 |=> !save_bank && !save_stack && !ovf_exc
      && !restore_bank && !underflow && $stable(bank_ptr)); // R3

  AST_BANKS_OFF: assert property (@(posedge clk) disable iff (rst)
    entry_valid && !bank_enable |=> !save_bank && !save_stack && !ovf_exc
      && $stable(bank_ptr)); // R4

  AST_STACK_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    banked_req && banks_full && !ovf_exc_enable |=> save_stack && $stable(bank_ptr)); // R5

  AST_OVERFLOW_EXC: assert property (@(posedge clk) disable iff (rst)
    banked_req && banks_full && ovf_exc_enable |=> ovf_exc && $stable(bank_ptr)); // R6

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    bank_ptr <= PTR_W'(NUM_BANKS)); // R7

  AST_POP: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !entry_valid && bank_ptr != '0 |=> restore_bank
      && restore_index == $past(bank_ptr) - 1'b1 && bank_ptr == $past(bank_ptr) - 1'b1); // R8

  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !entry_valid && bank_ptr == '0 |=> underflow && bank_ptr == '0); // R9

  AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (rst)
    entry_valid && ret_valid |=> !restore_bank && !underflow); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({save_bank, save_stack, ovf_exc, restore_bank, underflow})); // R11

endmodule

bind bank_save_alloc bsa_checker #(.NUM_BANKS(NUM_BANKS), .VEC_W(VEC_W)) u_bsa_checker (.*);

// File: tb/bank_save_alloc_bench.sv
module bank_save_alloc_bench;

  localparam int NB = 15;
  localparam int VW = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          entry_valid = 1'b0;
  logic [2:0]    entry_kind = '0;
  logic [VW-1:0] entry_vector = '0;
  logic          bank_enable = 1'b1;
  logic          ovf_exc_enable = 1'b0;
  logic          ret_valid = 1'b0;
  logic          save_bank, save_stack, ovf_exc, restore_bank, underflow, banks_full;
  logic [PW-1:0] save_index, restore_index, bank_ptr;
  logic [VW-1:0] save_vector, restore_vector;

  int errors = 0;
  int checks = 0;
  int mptr = 0;
  int mstack[$];

  bank_save_alloc u_bank_save_alloc (
    .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_kind(entry_kind),
    .entry_vector(entry_vector), .bank_enable(bank_enable),
    .ovf_exc_enable(ovf_exc_enable), .ret_valid(ret_valid),
    .save_bank(save_bank), .save_index(save_index), .save_vector(save_vector),
    .save_stack(save_stack), .ovf_exc(ovf_exc), .restore_bank(restore_bank),
    .restore_index(restore_index), .restore_vector(restore_vector),
    .underflow(underflow), .bank_ptr(bank_ptr), .banks_full(banks_full)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_common(input string tag, input int e_sb, input int e_ss,
                              input int e_ov, input int e_rb, input int e_un);
    chk(tag, "save_bank", int'(save_bank), e_sb);
    chk(tag, "save_stack", int'(save_stack), e_ss);
    chk(tag, "ovf_exc", int'(ovf_exc), e_ov);
    chk(tag, "restore_bank", int'(restore_bank), e_rb);
    chk(tag, "underflow", int'(underflow), e_un);
    chk(tag, "bank_ptr", int'(bank_ptr), mptr);
    chk("R7", "banks_full", int'(banks_full), int'(mptr == NB));
    chk("R11", "strobe count", $countones({save_bank, save_stack, ovf_exc, restore_bank, underflow}),
        e_sb + e_ss + e_ov + e_rb + e_un);
  endtask

  // Drive one cycle at a falling edge, predict, then compare at the next falling edge.
  task automatic step(input string tag, input bit ev, input int kind, input int vec,
                      input bit be, input bit oe, input bit rv);
    int e_sb = 0, e_ss = 0, e_ov = 0, e_rb = 0, e_un = 0, e_idx = 0, e_vec = 0;
    entry_valid = ev; entry_kind = kind[2:0]; entry_vector = vec[VW-1:0];
    bank_enable = be; ovf_exc_enable = oe; ret_valid = rv;
    if (ev) begin
      if (kind == 0 && be) begin
        if (mptr < NB) begin
          e_sb = 1; e_idx = mptr; e_vec = vec; mstack.push_back(vec); mptr++;
        end else if (oe) e_ov = 1;
        else e_ss = 1;
      end
    end else if (rv) begin
      if (mptr > 0) begin
        e_rb = 1; mptr--; e_idx = mptr; e_vec = mstack.pop_back();
      end else e_un = 1;
    end
    @(posedge clk);
    @(negedge clk);
    entry_valid = 1'b0; ret_valid = 1'b0;
    check_common(tag, e_sb, e_ss, e_ov, e_rb, e_un);
    if (e_sb == 1) begin
      chk(tag, "save_index", int'(save_index), e_idx);
      chk(tag, "save_vector", int'(save_vector), e_vec);
    end
    if (e_rb == 1) begin
      chk(tag, "restore_index", int'(restore_index), e_idx);
      chk(tag, "restore_vector", int'(restore_vector), e_vec);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; entry_valid = 1'b0; ret_valid = 1'b0;
    mptr = 0; mstack.delete();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_common("R1", 0, 0, 0, 0, 0);
    rst = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R3: non-banked kinds and unused codes
    for (int k = 1; k < 8; k++) step("R3", 1, k, 8'h10 + k, 1, 0, 0);
    // R4: banking disabled
    step("R4", 1, 0, 8'h21, 0, 0, 0);
    step("R4", 1, 0, 8'h22, 0, 1, 0);
    // R2: fill every bank
    for (int i = 0; i < NB; i++) step("R2", 1, 0, 8'h40 + i * 3, 1, 0, 0);
    // R5 / R6 at full
    step("R5", 1, 0, 8'h90, 1, 0, 0);
    step("R6", 1, 0, 8'h91, 1, 1, 0);
    step("R3", 1, 1, 8'h92, 1, 1, 0);
    // R10: entry and return together at full
    step("R10", 1, 0, 8'h93, 1, 0, 1);
    step("R10", 1, 4, 8'h94, 1, 0, 1);
    // R8: unwind all banks, vectors LIFO
    for (int i = 0; i < NB; i++) step("R8", 0, 0, 0, 1, 0, 1);
    // R9: return with nothing in use
    step("R9", 0, 0, 0, 1, 0, 1);
    step("R9", 0, 0, 0, 1, 1, 1);
    // Mixed ordering
    step("R2", 1, 0, 8'hA1, 1, 0, 0);
    step("R2", 1, 0, 8'hA2, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 1);
    step("R10", 1, 0, 8'hA3, 1, 0, 1);
    step("R10", 1, 2, 8'hA4, 1, 0, 1);
    step("R8", 0, 0, 0, 1, 0, 1);
    step("R8", 0, 0, 0, 1, 0, 1);
    step("R9", 0, 0, 0, 1, 0, 1);
    // R1: reset mid-run
    step("R2", 1, 0, 8'hB1, 1, 0, 0);
    step("R2", 1, 0, 8'hB2, 1, 0, 0);
    do_reset();
    step("R9", 0, 0, 0, 1, 0, 1);
    step("R2", 1, 0, 8'hC1, 1, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule